// File: doc/BRIEF.md
# Multi-channel light measurement sequencer

This block sits behind the register file of a four-channel light sensor, with red, green, blue and clear channels. A host writes a control register to request work. A measurement request integrates each channel in turn for its programmed number of time slots. It then asks an external converter for a 10-bit code and stores the code as a low/high byte pair. An offset request makes one dark conversion per channel, with no integration, and stores a signed sign-magnitude byte per channel.

Both command bits clear themselves when their run ends. The control register also shows a busy flag. An optional trim mode subtracts each channel's stored offset from its measurement and saturates the difference.

A sleep request freezes the sequencer. The request is only accepted while external-clock mode is selected. The slot tick and the converter handshake are single-bit strobes sampled on the core clock.

Top module: `lms_sequencer`

## Requirements
- R1: After reset every register reads 0, `busy` and `sleep_active` are 0 and `conv_start` is 0.
- R2: Register map, with unused bits reading 0:
  - address 0 is control: bit 0 requests a measurement, bit 1 requests an offset run, and bit 7 reads the busy flag.
  - address 1 is configuration: bit 0 selects trim, bit 1 requests sleep, bit 2 selects external clock.
  - addresses 2+c hold a 4-bit gain setting for channel c.
  - addresses 6+2c and 7+2c hold the low byte and the high nibble of channel c's 12-bit slot count.
  - addresses 64..71 hold results and cannot be written by the host.
  - addresses 72+c hold offsets, which the host may write.
- R3: A measurement stores channel c's 10-bit result with bits 7:0 at address 64+2c and bits 9:8 in bits 1:0 of address 65+2c. Control bit 0 clears itself once the last channel is stored.
- R4: For a channel with a nonzero count N, `conv_start` rises in the cycle after the N-th slot tick counted for that channel. Ticks seen before its integration window opens are not counted.
- R5: Channels are processed in the order red, green, blue, clear (`conv_chan` 0,1,2,3). A channel whose count is 0 gets no conversion and its result is stored as 0, whether or not trim is on.
- R6: An offset run requests one conversion per channel with `conv_dark`=1 and no slot ticks. It reads `conv_data` as a 10-bit two's complement value and stores it as a byte: bit 7 is the sign (1 negative), and bits 6:0 are the magnitude limited to 127.
- R7: If both command bits are pending, the offset run executes first and the measurement follows. `busy` and control bit 7 stay 1 until both bits have cleared.
- R8: A control write while `busy` is 1 is ignored: it neither starts another run nor cancels the running one.
- R9: With trim on, each stored measurement equals the converter code minus the channel's signed offset, limited to the range 0 to 1023.
- R10: The sleep bit is stored only when the same configuration write also sets external-clock mode; otherwise it reads back 0. `sleep_active` is 1 exactly while sleep is stored.
- R11: While `sleep_active` is 1 the sequencer is frozen: slot ticks are not counted and no conversion is requested. It resumes where it stopped on wake.
- R12: `conv_start` is a one-cycle pulse, and `conv_chan`/`conv_dark` stay valid until `conv_done`. The result is stored on the `conv_done` cycle and can be read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| slot_tick | input | 1 | One-cycle integration time-slot strobe |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 2 | Channel of the pending conversion |
| conv_dark | output | 1 | Pending conversion is a dark (offset) sample |
| conv_done | input | 1 | Converter result valid strobe |
| conv_data | input | 10 | Converter result code |
| busy | output | 1 | A command bit is still pending |
| sleep_active | output | 1 | Sequencer frozen by sleep |

## Verification
The results arrive at these edges:
- A result register changes on the edge that samples `conv_done`, so the bench reads it through `rd_data` at least one negative clock edge later.
- `conv_start` is high at the negative edge right after the edge that took the N-th counted tick. The bench checks that exact negedge and also checks that the pulse is absent at the negedges before it, including during a sleep window.
- Command bits fall two edges after the last `conv_done`. The bench therefore waits on `busy` before reading a run's results and compares them with values its own functions compute from the converter data it supplied.

// File: rtl/lms_pkg.sv
package lms_pkg;

    localparam int NCH     = 4;
    localparam int CH_W    = $clog2(NCH);
    localparam int RES_W   = 10;
    localparam int SLOT_W  = 12;
    localparam int CAP_W   = 4;
    localparam int AW      = 7;
    localparam int DW      = 8;
    localparam int MAG_W   = DW - 1;
    localparam int MAG_MAX = (1 << MAG_W) - 1;

    localparam logic [AW-1:0] ADR_CTRL = AW'(0);
    localparam logic [AW-1:0] ADR_CFG  = AW'(1);
    localparam int ADR_CAP_BASE = 2;
    localparam int ADR_INT_BASE = 6;
    localparam int ADR_RES_BASE = 64;
    localparam int ADR_OFF_BASE = 72;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_INTEG, S_CONV, S_WAIT, S_FIN
    } seq_state_e;

    typedef enum logic {
        RUN_LIGHT = 1'b0,
        RUN_DARK  = 1'b1
    } run_kind_e;

    typedef struct packed {
        logic             valid;
        logic             zero;
        run_kind_e        kind;
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] code;
    } store_t;

    typedef struct packed {
        logic ext;
        logic sleep;
        logic trim;
    } cfg_t;

    // Signed sign-magnitude offset removal, clamped to the result range.
    function automatic logic [RES_W-1:0] trim_apply(input logic [RES_W-1:0] raw,
                                                     input logic [DW-1:0]    off);
        logic [RES_W:0]   sum;
        logic [RES_W-1:0] mag;
        mag = RES_W'(off[MAG_W-1:0]);
        if (off[DW-1]) begin
            sum = {1'b0, raw} + {1'b0, mag};
            return sum[RES_W] ? '1 : sum[RES_W-1:0];
        end
        return (mag > raw) ? '0 : raw - mag;
    endfunction

    // Two's complement dark code to sign-magnitude byte with magnitude clamp.
    function automatic logic [DW-1:0] dark_encode(input logic [RES_W-1:0] code);
        logic             neg;
        logic [RES_W-1:0] mag;
        neg = code[RES_W-1];
        mag = neg ? (~code + 1'b1) : code;
        if (mag > RES_W'(MAG_MAX)) mag = RES_W'(MAG_MAX);
        return {neg, mag[MAG_W-1:0]};
    endfunction

endpackage

// File: rtl/lms_slot_timer.sv
module lms_slot_timer
    import lms_pkg::*;
#(
    parameter int SLOT_W_P = SLOT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                tick,
    input  logic [SLOT_W_P-1:0] target,
    output logic                reached
);

    logic [SLOT_W_P-1:0] cnt_q;
    logic [SLOT_W_P-1:0] cnt_nx;

    assign cnt_nx  = cnt_q + 1'b1;
    assign reached = tick && (cnt_nx == target);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_nx;
    end

endmodule

// File: rtl/lms_seq.sv
module lms_seq
    import lms_pkg::*;
#(
    parameter int NCH_P    = NCH,
    parameter int SLOT_W_P = SLOT_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cmd_meas,
    input  logic                           cmd_dark,
    input  logic                           sleep,
    input  logic                           slot_tick,
    input  logic [NCH_P-1:0][SLOT_W_P-1:0] int_cnt,
    input  logic                           tmr_reached,
    output logic                           tmr_clear,
    output logic                           tmr_tick,
    output logic [SLOT_W_P-1:0]            tmr_target,
    output logic                           conv_start,
    output logic [CH_W-1:0]                conv_chan,
    output logic                           conv_dark,
    input  logic                           conv_done,
    input  logic [RES_W-1:0]               conv_data,
    output store_t                         store,
    output logic                           fin_pulse,
    output run_kind_e                      fin_kind
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH_P - 1);

    seq_state_e      state_q, state_d;
    run_kind_e       kind_q, kind_d;
    logic [CH_W-1:0] ch_q, ch_d;
    logic            zero_cnt;
    logic            run;

    assign run        = !sleep;
    assign tmr_target = int_cnt[ch_q];
    assign zero_cnt   = (tmr_target == '0);
    assign tmr_clear  = (state_q == S_SETUP);
    assign tmr_tick   = run && slot_tick && (state_q == S_INTEG);
    assign conv_start = run && (state_q == S_CONV);
    assign conv_chan  = ch_q;
    assign conv_dark  = (kind_q == RUN_DARK);
    assign fin_pulse  = run && (state_q == S_FIN);
    assign fin_kind   = kind_q;

    always_comb begin
        store       = '0;
        store.kind  = kind_q;
        store.ch    = ch_q;
        store.code  = conv_data;
        if (run && state_q == S_SETUP && kind_q == RUN_LIGHT && zero_cnt) begin
            store.valid = 1'b1;
            store.zero  = 1'b1;
        end else if (run && state_q == S_WAIT && conv_done) begin
            store.valid = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        ch_d    = ch_q;
        if (run) begin
            unique case (state_q)
                S_IDLE: begin
                    if (cmd_dark || cmd_meas) begin
                        kind_d  = cmd_dark ? RUN_DARK : RUN_LIGHT;
                        ch_d    = '0;
                        state_d = S_SETUP;
                    end
                end
                S_SETUP: begin
                    if (kind_q == RUN_DARK) state_d = S_CONV;
                    else if (!zero_cnt)     state_d = S_INTEG;
                    else if (ch_q == LAST_CH) state_d = S_FIN;
                    else begin
                        ch_d = ch_q + 1'b1;
                    end
                end
                S_INTEG: if (tmr_reached) state_d = S_CONV;
                S_CONV:  state_d = S_WAIT;
                S_WAIT: begin
                    if (conv_done) begin
                        if (ch_q == LAST_CH) state_d = S_FIN;
                        else begin
                            ch_d    = ch_q + 1'b1;
                            state_d = S_SETUP;
                        end
                    end
                end
                S_FIN:   state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            kind_q  <= RUN_LIGHT;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            ch_q    <= ch_d;
        end
    end

    // R11: a frozen sequencer keeps its state and channel
    a_r11_sleep_freeze: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(state_q) && $stable(ch_q)));

    // R5: channels only step forward by one, or restart at red
    a_r5_channel_order: assert property (@(posedge clk) disable iff (rst)
        (ch_q != $past(ch_q)) |-> (ch_q == $past(ch_q) + 1'b1 || ch_q == '0));

    // R12: conversion request lasts a single cycle
    a_r12_start_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R12: channel and kind held while the converter works
    a_r12_chan_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && !conv_done) |=> ($stable(conv_chan) && $stable(conv_dark)));

endmodule

// File: rtl/lms_regs.sv
module lms_regs
    import lms_pkg::*;
#(
    parameter int NCH_P    = NCH,
    parameter int SLOT_W_P = SLOT_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  wr_addr,
    input  logic [DW-1:0]                  wr_data,
    input  logic [AW-1:0]                  rd_addr,
    output logic [DW-1:0]                  rd_data,
    input  store_t                         store,
    input  logic                           fin_pulse,
    input  run_kind_e                      fin_kind,
    output logic                           cmd_meas,
    output logic                           cmd_dark,
    output cfg_t                           cfg,
    output logic [NCH_P-1:0][SLOT_W_P-1:0] int_cnt,
    output logic                           busy
);

    localparam int HI_W = SLOT_W_P - DW;

    logic cmd_meas_q, cmd_dark_q;
    cfg_t cfg_q;

    logic [DW-1:0] ch_rd  [NCH_P];
    logic          ch_hit [NCH_P];

    assign cmd_meas = cmd_meas_q;
    assign cmd_dark = cmd_dark_q;
    assign cfg      = cfg_q;
    assign busy     = cmd_meas_q || cmd_dark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_meas_q <= 1'b0;
            cmd_dark_q <= 1'b0;
            cfg_q      <= '0;
        end else begin
            if (fin_pulse) begin
                if (fin_kind == RUN_DARK) cmd_dark_q <= 1'b0;
                else                      cmd_meas_q <= 1'b0;
            end else if (wr_en && wr_addr == ADR_CTRL && !busy) begin
                cmd_meas_q <= wr_data[0];
                cmd_dark_q <= wr_data[1];
            end
            if (wr_en && wr_addr == ADR_CFG) begin
                cfg_q.trim  <= wr_data[0];
                cfg_q.ext   <= wr_data[2];
                cfg_q.sleep <= wr_data[1] && wr_data[2];
            end
        end
    end

    for (genvar c = 0; c < NCH_P; c++) begin : g_ch
        localparam logic [AW-1:0] A_CAP = AW'(ADR_CAP_BASE + c);
        localparam logic [AW-1:0] A_ILO = AW'(ADR_INT_BASE + 2 * c);
        localparam logic [AW-1:0] A_IHI = AW'(ADR_INT_BASE + 2 * c + 1);
        localparam logic [AW-1:0] A_RLO = AW'(ADR_RES_BASE + 2 * c);
        localparam logic [AW-1:0] A_RHI = AW'(ADR_RES_BASE + 2 * c + 1);
        localparam logic [AW-1:0] A_OFF = AW'(ADR_OFF_BASE + c);

        logic [CAP_W-1:0] cap_q;
        logic [DW-1:0]    ilo_q;
        logic [HI_W-1:0]  ihi_q;
        logic [RES_W-1:0] res_q;
        logic [DW-1:0]    off_q;
        logic             mine;

        assign mine       = store.valid && (store.ch == CH_W'(c));
        assign int_cnt[c] = {ihi_q, ilo_q};

        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q <= '0;
                ilo_q <= '0;
                ihi_q <= '0;
                res_q <= '0;
                off_q <= '0;
            end else begin
                if (wr_en && wr_addr == A_CAP) cap_q <= wr_data[CAP_W-1:0];
                if (wr_en && wr_addr == A_ILO) ilo_q <= wr_data;
                if (wr_en && wr_addr == A_IHI) ihi_q <= wr_data[HI_W-1:0];
                if (mine && store.kind == RUN_DARK) begin
                    off_q <= dark_encode(store.code);
                end else if (wr_en && wr_addr == A_OFF) begin
                    off_q <= wr_data;
                end
                if (mine && store.kind == RUN_LIGHT) begin
                    if (store.zero)      res_q <= '0;
                    else if (cfg_q.trim) res_q <= trim_apply(store.code, off_q);
                    else                 res_q <= store.code;
                end
            end
        end

        always_comb begin
            ch_hit[c] = 1'b1;
            ch_rd[c]  = '0;
            if (rd_addr == A_CAP)      ch_rd[c] = DW'(cap_q);
            else if (rd_addr == A_ILO) ch_rd[c] = ilo_q;
            else if (rd_addr == A_IHI) ch_rd[c] = DW'(ihi_q);
            else if (rd_addr == A_RLO) ch_rd[c] = res_q[DW-1:0];
            else if (rd_addr == A_RHI) ch_rd[c] = DW'(res_q[RES_W-1:DW]);
            else if (rd_addr == A_OFF) ch_rd[c] = off_q;
            else                       ch_hit[c] = 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_CTRL)     rd_data = {busy, 5'b0, cmd_dark_q, cmd_meas_q};
        else if (rd_addr == ADR_CFG) rd_data = DW'(cfg_q);
        else begin
            for (int c = 0; c < NCH_P; c++) begin
                if (ch_hit[c]) rd_data = ch_rd[c];
            end
        end
    end

    // R10: sleep is never held without external-clock mode
    a_r10_sleep_needs_ext: assert property (@(posedge clk) disable iff (rst)
        cfg_q.sleep |-> cfg_q.ext);

    // R8: a control write during a run cannot raise a command bit
    a_r8_ctrl_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_addr == ADR_CTRL) |=> !($rose(cmd_meas_q) || $rose(cmd_dark_q)));

    // R3: results are only written while a command is pending
    a_r3_store_in_run: assert property (@(posedge clk) disable iff (rst)
        store.valid |-> busy);

endmodule

// File: rtl/lms_sequencer.sv
module lms_sequencer
    import lms_pkg::*;
#(
    parameter int SLOT_W_P = SLOT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             slot_tick,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             conv_dark,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             busy,
    output logic             sleep_active
);

    logic                        cmd_meas, cmd_dark;
    cfg_t                        cfg;
    logic [NCH-1:0][SLOT_W_P-1:0] int_cnt;
    store_t                      store;
    logic                        fin_pulse;
    run_kind_e                   fin_kind;
    logic                        tmr_clear, tmr_tick, tmr_reached;
    logic [SLOT_W_P-1:0]         tmr_target;

    assign sleep_active = cfg.sleep && cfg.ext;

    lms_regs #(.NCH_P(NCH), .SLOT_W_P(SLOT_W_P)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .store(store), .fin_pulse(fin_pulse), .fin_kind(fin_kind),
        .cmd_meas(cmd_meas), .cmd_dark(cmd_dark), .cfg(cfg),
        .int_cnt(int_cnt), .busy(busy)
    );

    lms_seq #(.NCH_P(NCH), .SLOT_W_P(SLOT_W_P)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_meas(cmd_meas), .cmd_dark(cmd_dark), .sleep(sleep_active),
        .slot_tick(slot_tick), .int_cnt(int_cnt),
        .tmr_reached(tmr_reached), .tmr_clear(tmr_clear),
        .tmr_tick(tmr_tick), .tmr_target(tmr_target),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_dark(conv_dark),
        .conv_done(conv_done), .conv_data(conv_data),
        .store(store), .fin_pulse(fin_pulse), .fin_kind(fin_kind)
    );

    lms_slot_timer #(.SLOT_W_P(SLOT_W_P)) u_tmr (
        .clk(clk), .rst(rst),
        .clear(tmr_clear), .tick(tmr_tick),
        .target(tmr_target), .reached(tmr_reached)
    );

endmodule

// File: tb/sim_lms_sequencer.sv
module sim_lms_sequencer;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       slot_tick = 1'b0;
    logic       conv_start;
    logic [1:0] conv_chan;
    logic       conv_dark;
    logic       conv_done;
    logic [9:0] conv_data;
    logic       busy;
    logic       sleep_active;

    int checks = 0;
    int fails  = 0;

    // converter model data and log
    logic [9:0] light_v [4];
    logic [9:0] dark_v  [4];
    int         conv_lat = 1;
    int         conv_cnt = 0;
    logic [1:0] log_ch [512];
    logic       log_dk [512];

    // bench model of register contents
    int         cnt_m [4];
    logic [7:0] off_m [4];
    int         res_m [4];
    logic       trim_m = 1'b0;

    always #2 clk = ~clk;

    lms_sequencer u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .slot_tick(slot_tick),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_dark(conv_dark),
        .conv_done(conv_done), .conv_data(conv_data),
        .busy(busy), .sleep_active(sleep_active)
    );

    initial begin
        conv_done = 1'b0;
        conv_data = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_start) begin
                logic [1:0] ch;
                logic       dk;
                ch = conv_chan;
                dk = conv_dark;
                log_ch[conv_cnt % 512] = ch;
                log_dk[conv_cnt % 512] = dk;
                conv_cnt++;
                repeat (conv_lat) @(negedge clk);
                conv_done = 1'b1;
                conv_data = dk ? dark_v[ch] : light_v[ch];
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic tick_once();
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 4000) begin
            @(negedge clk);
            slot_tick = 1'($urandom % 2);
            n++;
        end
        slot_tick = 1'b0;
        chk(tag, int'(busy), 0);
    endtask

    function automatic int exp_trim(input int raw, input logic [7:0] off);
        int v = off[7] ? raw + int'(off[6:0]) : raw - int'(off[6:0]);
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    function automatic logic [7:0] exp_dark(input logic [9:0] code);
        int v = code[9] ? int'(code) - 1024 : int'(code);
        logic s = (v < 0);
        if (v < 0) v = -v;
        if (v > 127) v = 127;
        return {s, 7'(v)};
    endfunction

    task automatic set_counts();
        for (int c = 0; c < 4; c++) begin
            wr(7'(6 + 2 * c), 8'(cnt_m[c]));
            wr(7'(7 + 2 * c), 8'(cnt_m[c] >> 8));
        end
    endtask

    task automatic model_run(input logic [1:0] cmd);
        if (cmd[1]) for (int c = 0; c < 4; c++) off_m[c] = exp_dark(dark_v[c]);
        if (cmd[0]) for (int c = 0; c < 4; c++)
            res_m[c] = (cnt_m[c] == 0) ? 0 :
                       (trim_m ? exp_trim(int'(light_v[c]), off_m[c]) : int'(light_v[c]));
    endtask

    task automatic check_regs(input string tag);
        logic [7:0] lo, hi, o;
        for (int c = 0; c < 4; c++) begin
            rd(7'(64 + 2 * c), lo);
            rd(7'(65 + 2 * c), hi);
            chk({tag, " R3 result"}, int'({hi, lo}), res_m[c]);
            rd(7'(72 + c), o);
            chk({tag, " R6 offset"}, int'(o), int'(off_m[c]));
        end
    endtask

    initial begin
        logic [7:0] v;
        int base;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 4; c++) begin
            cnt_m[c] = 0; off_m[c] = '0; res_m[c] = 0;
        end

        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 sleep_active", int'(sleep_active), 0);
        chk("R1 conv_start", int'(conv_start), 0);
        rd(7'd0, v);  chk("R1 ctrl", int'(v), 0);
        rd(7'd1, v);  chk("R1 cfg", int'(v), 0);
        rd(7'd67, v); chk("R1 result", int'(v), 0);

        // R2: field widths and read-only results
        wr(7'd3, 8'hFF);  rd(7'd3, v);  chk("R2 gain 4 bits", int'(v), 8'h0F);
        wr(7'd9, 8'hFF);  rd(7'd9, v);  chk("R2 count high nibble", int'(v), 8'h0F);
        wr(7'd9, 8'h00);
        wr(7'd64, 8'hAA); rd(7'd64, v); chk("R2 result not writable", int'(v), 0);

        // R10: sleep only with external clock
        wr(7'd1, 8'h02);  rd(7'd1, v);  chk("R10 sleep dropped", int'(v), 0);
        chk("R10 no sleep_active", int'(sleep_active), 0);
        wr(7'd1, 8'h06);  rd(7'd1, v);  chk("R10 sleep kept", int'(v), 8'h06);
        chk("R10 sleep_active", int'(sleep_active), 1);
        wr(7'd1, 8'h00);  chk("R10 ext cleared wakes", int'(sleep_active), 0);

        // R4, R5, R8: directed measurement
        cnt_m[0] = 3; cnt_m[1] = 0; cnt_m[2] = 2; cnt_m[3] = 1;
        light_v[0] = 10'd700; light_v[1] = 10'd400; light_v[2] = 10'd5; light_v[3] = 10'd1023;
        set_counts();
        conv_lat = 1;
        base = conv_cnt;
        tick_once();  // R4: tick before the run is not counted
        wr(7'd0, 8'h01);
        repeat (3) @(negedge clk);
        tick_once();
        tick_once();
        chk("R4 no start after 2 of 3 ticks", int'(conv_start), 0);
        @(negedge clk);
        chk("R4 still no start", int'(conv_start), 0);
        tick_once();
        chk("R4 start after third tick", int'(conv_start), 1);
        chk("R5 first channel red", int'(conv_chan), 0);
        repeat (4) @(negedge clk);
        rd(7'd0, v); chk("R7 busy bit in control", int'(v), 8'h81);
        wr(7'd0, 8'h02);   // R8: must not queue an offset run
        wr(7'd0, 8'h00);   // R8: must not cancel
        rd(7'd0, v); chk("R8 control unchanged", int'(v), 8'h81);
        wait_idle("R3 measurement ends");
        model_run(2'b01);
        rd(7'd0, v); chk("R3 command self-cleared", int'(v), 0);
        chk("R5 conversions skip zero count", conv_cnt - base, 3);
        chk("R5 order second blue", int'(log_ch[(base + 1) % 512]), 2);
        chk("R5 order third clear", int'(log_ch[(base + 2) % 512]), 3);
        chk("R8 no dark conversion", int'(log_dk[(base + 2) % 512]), 0);
        check_regs("directed");

        // R6: offset run with sign and clamp cases
        dark_v[0] = 10'h3FD; dark_v[1] = 10'd200; dark_v[2] = 10'h200; dark_v[3] = 10'd0;
        base = conv_cnt;
        wr(7'd0, 8'h02);
        wait_idle("R6 offset run ends");
        model_run(2'b10);
        chk("R6 four dark conversions", conv_cnt - base, 4);
        chk("R6 dark flag", int'(log_dk[base % 512]), 1);
        rd(7'd72, v); chk("R6 negative small", int'(v), 8'h83);
        rd(7'd73, v); chk("R6 positive clamp", int'(v), 8'h7F);
        rd(7'd74, v); chk("R6 negative clamp", int'(v), 8'hFF);
        check_regs("offset");

        // R9: trim with saturation, R5 zero count under trim
        off_m[0] = 8'h05; off_m[1] = 8'h85; off_m[2] = 8'h10; off_m[3] = 8'h81;
        for (int c = 0; c < 4; c++) wr(7'(72 + c), off_m[c]);
        cnt_m[0] = 1; cnt_m[1] = 1; cnt_m[2] = 1; cnt_m[3] = 0;
        set_counts();
        light_v[0] = 10'd3; light_v[1] = 10'd1020; light_v[2] = 10'd100; light_v[3] = 10'd50;
        trim_m = 1'b1; wr(7'd1, 8'h01);
        wr(7'd0, 8'h01);
        wait_idle("R9 trimmed run ends");
        model_run(2'b01);
        rd(7'd64, v); chk("R9 floor at 0", int'(v), 0);
        rd(7'd67, v); chk("R9 ceiling high byte", int'(v), 3);
        rd(7'd68, v); chk("R9 subtract", int'(v), 84);
        rd(7'd70, v); chk("R5 zero count stays 0 under trim", int'(v), 0);
        check_regs("trim");

        // R11: sleep freezes integration
        cnt_m[0] = 2; cnt_m[1] = 0; cnt_m[2] = 0; cnt_m[3] = 0;
        set_counts();
        trim_m = 1'b0; wr(7'd1, 8'h04);
        wr(7'd0, 8'h01);
        repeat (3) @(negedge clk);
        tick_once();
        wr(7'd1, 8'h06);
        for (int i = 0; i < 5; i++) begin
            tick_once();
            chk("R11 no start while asleep", int'(conv_start), 0);
        end
        chk("R11 still busy", int'(busy), 1);
        wr(7'd1, 8'h04);
        tick_once();
        chk("R11 resumes after wake", int'(conv_start), 1);
        wait_idle("R11 run ends");
        model_run(2'b01);
        check_regs("sleep");

        // R7: both commands, offset first
        dark_v[0] = 10'd7; dark_v[1] = 10'h3F0; dark_v[2] = 10'd1; dark_v[3] = 10'd100;
        cnt_m[0] = 1; cnt_m[1] = 2; cnt_m[2] = 1; cnt_m[3] = 1;
        set_counts();
        trim_m = 1'b1; wr(7'd1, 8'h05);
        base = conv_cnt;
        wr(7'd0, 8'h03);
        wait_idle("R7 combined run ends");
        model_run(2'b11);
        chk("R7 eight conversions", conv_cnt - base, 8);
        chk("R7 dark first", int'(log_dk[base % 512]), 1);
        chk("R7 light last", int'(log_dk[(base + 7) % 512]), 0);
        check_regs("combined");

        // R12 and all requirements under random mixes
        for (int it = 0; it < 20; it++) begin
            logic [1:0] cmd;
            cmd = 2'(1 + $urandom % 3);
            conv_lat = 1 + $urandom % 3;
            for (int c = 0; c < 4; c++) begin
                cnt_m[c]   = $urandom % 5;
                light_v[c] = 10'($urandom);
                dark_v[c]  = 10'($urandom);
            end
            set_counts();
            trim_m = 1'($urandom % 2);
            wr(7'd1, {5'b0, 2'b10, trim_m});
            wr(7'd0, {6'b0, cmd});
            wait_idle("R12 random run ends");
            model_run(cmd);
            check_regs("R12 random");
        end

        summary();
    end

endmodule